// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a serial management master for an external Ethernet PHY. A host programs it through four word-wide registers: a control register that enables the interface and sets the management clock divider, a command register, a write-data register and a read-data register. Writing the command register with its start flag set launches one clause-22 transaction. The transaction can be a register write, which sends the write-data value, or a register read, which loads the PHY's reply into the read-data register.

On the wire each transaction is a 64-bit frame. It starts with a preamble of 32 ones and the start code 01. Then come the two-bit operation code (01 for write, 10 for read), the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits. The block drives the management clock only while a frame is in flight. It changes its data output on the falling clock edge and samples the PHY on the rising edge. The line is expected to have a pull-up, so a read from an address where no PHY answers returns all ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The control register (host address 0) holds only bits 6:0. Bit 6 is the enable, bits 5:0 are the divider `d`, and every other bit reads back as 0.
- R2: When enable is 1 and the divider is 0, `cfg_err` is 1; otherwise it is 0. While that condition holds, a start request launches nothing and the management clock stays low.
- R3: The command register (host address 1) takes the PHY address in bits 28:24, the register address in bits 20:16, the operation in bits 15:14 and the start flag in bit 11. Operation 1 writes the low 16 bits of the write-data register (host address 2) and leaves the read-data register unchanged.
- R4: Operation 2 shifts in 16 data bits, most significant first. After the frame ends, the read-data register (host address 3, bits 15:0) holds them. Host writes to address 3 are ignored.
- R5: A start flag of 0, an operation of 0 or 3, or an enable of 0 starts no transaction. In that case the management clock stays low and the output driver stays off.
- R6: A read from a PHY address with no responder returns 0xFFFF.
- R7: Reading the command register returns the stored word with bit 7 replaced by the ready flag. Ready is 0 from the start edge until the last data bit's falling clock edge, and 1 otherwise. Host reads are registered and reflect the state before the clock edge that captures them.
- R8: The frame bits go out in the fixed order 32 ones, 01, operation, PHY address, register address, turnaround, data, each address most significant bit first. A write drives the turnaround as 1 then 0. A read releases the line (`mdio_oe`=0) for the turnaround and all 16 data bits.
- R9: The management clock has a period of 2×(d+1) system clocks: d+1 cycles low, then d+1 cycles high, starting low on the cycle after the start edge. `mdio_o` changes only together with a falling clock edge, and input is captured on the rising edge. A frame lasts 128×(d+1) cycles, using the divider value latched at start.
- R10: A start request that arrives while a transaction is in flight is ignored, and the running frame continues unchanged.
- R11: After reset, all registers read 0 except the ready flag, which reads 1. `mdc`, `mdio_oe`, `mdio_o` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 2 | Register write address |
| host_wdata | input | 32 | Register write data |
| host_raddr | input | 2 | Register read address |
| host_rdata | output | 32 | Registered read data, one cycle after the address |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input (line with pull-up) |
| cfg_err | output | 1 | Enabled with a zero divider |

## Verification
A behavioural model predicts `mdc`, `mdio_oe`, `mdio_o` and the ready flag for every cycle. Writes and reads are run at dividers 1, 2 and 3. Comparing frames that differ only in divider shows whether the clock period scales and whether the divider is latched at start. A write to register 31 checks that each address field lands in its own bit position. Reads from a present PHY and from an empty address show apart real captured data and the pull-up value. Start requests with a bad operation, the enable off, a zero divider, or a transaction already running must leave the wire quiet, and show that the start qualification works.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int CTRL_W    = 7;
  localparam int DIV_W     = 6;
  localparam int BIT_W     = $clog2(FRAME_LEN);

  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_OP_LSB  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;
  localparam int CTRL_EN_BIT = 6;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CMD   = 2'd1,
    SEL_WDATA = 2'd2,
    SEL_RDATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic              rd;
    logic [DATA_W-1:0] wdata;
  } xfer_t;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        waddr,
  input  logic [HW-1:0]     wdata,
  input  logic [1:0]        raddr,
  output logic [HW-1:0]     rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_rd,
  input  logic [DATA_W-1:0] capture,
  output logic              launch,
  output xfer_t             req,
  output logic [DIV_W-1:0]  div,
  output logic              cfg_err
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [HW-1:0]     cmd_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic [HW-1:0]     rdata_q;
  logic [1:0]        op_in;
  logic              en;
  logic              op_ok;

  assign en      = ctrl_q[CTRL_EN_BIT];
  assign div     = ctrl_q[DIV_W-1:0];
  assign cfg_err = en && (div == '0);
  assign op_in   = wdata[CMD_OP_LSB +: 2];
  assign op_ok   = (op_in == OP_WR) || (op_in == OP_RD);

  assign launch = we && (reg_sel_e'(waddr) == SEL_CMD) && wdata[CMD_GO_BIT]
                  && !busy && en && (div != '0) && op_ok;

  assign req.phy   = wdata[CMD_PHY_LSB +: ADDR_W];
  assign req.regad = wdata[CMD_REG_LSB +: ADDR_W];
  assign req.rd    = (op_in == OP_RD);
  assign req.wdata = wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (we) begin
        case (reg_sel_e'(waddr))
          SEL_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
          SEL_CMD:   cmd_q  <= wdata;
          SEL_WDATA: wd_q   <= wdata[DATA_W-1:0];
          default:   ;
        endcase
      end
      if (done && done_rd) rd_q <= capture;
      case (reg_sel_e'(raddr))
        SEL_CTRL:  rdata_q <= HW'(ctrl_q);
        SEL_CMD: begin
          rdata_q              <= cmd_q;
          rdata_q[CMD_RDY_BIT] <= !busy;
        end
        SEL_WDATA: rdata_q <= HW'(wd_q);
        default:   rdata_q <= HW'(rd_q);
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= '0;
      mdc_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      div_q <= div;
      mdc_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == div_q) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end
  end

  assign mdc  = mdc_q;
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  xfer_t             req,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] capture
);
  logic [FRAME_LEN-1:0] frame_q;
  logic [FRAME_LEN-1:0] frame_new;
  logic [BIT_W-1:0]     bit_q;
  logic [BIT_W-1:0]     nxt;
  logic                 rd_q;
  logic                 busy_q;
  logic                 o_q;
  logic                 oe_q;
  logic                 done_q;
  logic [DATA_W-1:0]    cap_q;
  logic                 last;

  assign frame_new = {{PRE_LEN{1'b1}}, 2'b01,
                      req.rd ? OP_RD : OP_WR,
                      req.phy, req.regad,
                      req.rd ? 2'b11 : 2'b10,
                      req.rd ? {DATA_W{1'b1}} : req.wdata};
  assign nxt  = bit_q + 1'b1;
  assign last = (bit_q == BIT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      o_q     <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch && !busy_q) begin
        frame_q <= frame_new;
        bit_q   <= '0;
        busy_q  <= 1'b1;
        rd_q    <= req.rd;
        o_q     <= frame_new[FRAME_LEN-1];
        oe_q    <= 1'b1;
        cap_q   <= '0;
      end else if (busy_q) begin
        if (rise && rd_q && (bit_q >= BIT_W'(DATA_POS)))
          cap_q <= {cap_q[DATA_W-2:0], mdio_i};
        if (fall) begin
          if (last) begin
            busy_q <= 1'b0;
            o_q    <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q   <= nxt;
            frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
            o_q     <= frame_q[FRAME_LEN-2];
            oe_q    <= !(rd_q && (nxt >= BIT_W'(TA_POS)));
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign done    = done_q;
  assign done_rd = rd_q;
  assign capture = cap_q;

  // R10: a running frame only moves forward, never restarts
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> (bit_q >= $past(bit_q)));

  // R8: a read leaves the line released from turnaround onward
  p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rd_q && (bit_q >= BIT_W'(TA_POS))) |-> !oe_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_waddr,
  input  logic [HW-1:0] host_wdata,
  input  logic [1:0]    host_raddr,
  output logic [HW-1:0] host_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i,
  output logic          cfg_err
);
  logic              launch;
  xfer_t             req;
  logic [DIV_W-1:0]  div;
  logic              busy;
  logic              done;
  logic              done_rd;
  logic [DATA_W-1:0] capture;
  logic              rise;
  logic              fall;

  mdio_regs #(.HW(HW)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .waddr(host_waddr),
    .wdata(host_wdata), .raddr(host_raddr), .rdata(host_rdata),
    .busy(busy), .done(done), .done_rd(done_rd), .capture(capture),
    .launch(launch), .req(req), .div(div), .cfg_err(cfg_err)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .start(launch), .run(busy), .div(div),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .launch(launch), .req(req), .rise(rise),
    .fall(fall), .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .done_rd(done_rd), .capture(capture)
  );

  // R2: a zero-divider configuration never starts a frame
  p_cfg_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !busy) |=> !busy);

  // R11 / R5: idle means clock low and driver off
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R9: data output moves only with a falling management clock
  p_out_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [1:0]  host_raddr = 2'd1;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i, cfg_err;
  logic        phy_bit = 1'b1;

  int total = 0;
  int bad = 0;
  int rises = 0;
  logic mdc_last = 1'b0;

  localparam int PHY_AT = 7;

  always #4 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .cfg_err(cfg_err)
  );

  // model state
  bit          m_busy = 0;
  int          m_k = 0;
  int          m_d = 0;
  bit          m_rdop = 0;
  bit          m_en = 0;
  int          m_div = 0;
  logic [15:0] m_wd = '0;
  logic [15:0] m_resp = '0;
  logic [15:0] m_rval = '0;
  logic [63:0] m_frame = '0;
  bit          m_ready_exp = 1;
  bit          m_chk = 0;

  function automatic logic [15:0] phy_val(int r);
    return 16'(16'h9000 + r * 16'h0113);
  endfunction

  function automatic logic [63:0] exp_frame(int phy, int r, bit rd, logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, 5'(phy), 5'(r),
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
  endfunction

  function automatic logic [31:0] cmdw(int phy, int r, int op, bit go);
    return (32'(phy) << 24) | (32'(r) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_en = 0; m_div = 0; m_wd = '0; m_rval = '0;
      m_ready_exp = 1; m_chk = 0;
    end else begin
      m_ready_exp = !m_busy;
      m_chk = (host_raddr == 2'd1);
      if (m_busy) begin
        m_k++;
        if (m_k == 128 * (m_d + 1)) begin
          m_busy = 0;
          if (m_rdop) m_rval = m_resp;
        end
      end else if (host_we && host_waddr == 2'd1 && host_wdata[11] && m_en &&
                   m_div != 0 && (host_wdata[15:14] == 2'd1 || host_wdata[15:14] == 2'd2)) begin
        m_busy = 1; m_k = 0; m_d = m_div;
        m_rdop = (host_wdata[15:14] == 2'd2);
        m_frame = exp_frame(int'(host_wdata[28:24]), int'(host_wdata[20:16]), m_rdop, m_wd);
        m_resp = (int'(host_wdata[28:24]) == PHY_AT) ? phy_val(int'(host_wdata[20:16])) : 16'hFFFF;
      end
      if (host_we && host_waddr == 2'd0) begin
        m_en = host_wdata[6];
        m_div = int'(host_wdata[5:0]);
      end
      if (host_we && host_waddr == 2'd2) m_wd = host_wdata[15:0];
    end
  end

  // per-cycle comparison and PHY response
  always @(negedge clk) begin
    if (!rst) begin
      int b;
      bit e_mdc, e_oe;
      b = m_k / (2 * (m_d + 1));
      e_mdc = m_busy ? (((m_k / (m_d + 1)) % 2) == 1) : 1'b0;
      e_oe = m_busy && !(m_rdop && b >= 46);
      total++;
      if (mdc !== e_mdc) begin
        bad++; $display("FAIL R9 mdc actual=%b expected=%b k=%0d", mdc, e_mdc, m_k);
      end
      total++;
      if (mdio_oe !== e_oe) begin
        bad++; $display("FAIL R8 mdio_oe actual=%b expected=%b bit=%0d", mdio_oe, e_oe, b);
      end
      if (e_oe) begin
        total++;
        if (mdio_o !== m_frame[63 - b]) begin
          bad++; $display("FAIL R8 mdio_o actual=%b expected=%b bit=%0d", mdio_o, m_frame[63 - b], b);
        end
      end
      if (m_chk) begin
        total++;
        if (host_rdata[7] !== m_ready_exp) begin
          bad++; $display("FAIL R7 ready actual=%b expected=%b", host_rdata[7], m_ready_exp);
        end
      end
      if (mdc && !mdc_last) rises++;
      mdc_last = mdc;
      if (m_busy && m_rdop && m_resp != 16'hFFFF && b == 47) phy_bit = 1'b0;
      else if (m_busy && m_rdop && b >= 48) phy_bit = m_resp[15 - (b - 48)];
      else phy_bit = 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_check(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    host_raddr = a;
    @(negedge clk);
    chk(tag, host_rdata, exp);
    host_raddr = 2'd1;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 mdc", {31'd0, mdc}, 32'd0);
    chk("R11 mdio_oe", {31'd0, mdio_oe}, 32'd0);
    chk("R11 mdio_o", {31'd0, mdio_o}, 32'd0);
    chk("R11 cfg_err", {31'd0, cfg_err}, 32'd0);
    rd_check(2'd0, 32'd0, "R11 ctrl");
    rd_check(2'd1, 32'h80, "R11 cmd");
    rd_check(2'd2, 32'd0, "R11 wdata");
    rd_check(2'd3, 32'd0, "R11 rdata");

    // R1 only low 7 bits kept
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check(2'd0, 32'h7F, "R1 ctrl mask");

    // R2 enabled with zero divider
    wr(2'd0, 32'h40);
    @(negedge clk);
    chk("R2 cfg_err set", {31'd0, cfg_err}, 32'd1);
    rises = 0;
    wr(2'd1, cmdw(PHY_AT, 1, 2, 1));
    repeat (40) @(negedge clk);
    chk("R2 no mdc", 32'(rises), 32'd0);
    wr(2'd0, 32'h00);
    @(negedge clk);
    chk("R2 cfg_err clear", {31'd0, cfg_err}, 32'd0);

    // R5 disabled interface
    wr(2'd0, 32'h03);
    rises = 0;
    wr(2'd1, cmdw(PHY_AT, 2, 2, 1));
    repeat (30) @(negedge clk);
    chk("R5 disabled no mdc", 32'(rises), 32'd0);

    // R5 opcode 0 and 3, start flag 0
    wr(2'd0, 32'h41);
    rises = 0;
    wr(2'd1, cmdw(PHY_AT, 2, 0, 1));
    repeat (20) @(negedge clk);
    wr(2'd1, cmdw(PHY_AT, 2, 3, 1));
    repeat (20) @(negedge clk);
    wr(2'd1, cmdw(PHY_AT, 2, 2, 0));
    repeat (20) @(negedge clk);
    chk("R5 bad op no mdc", 32'(rises), 32'd0);
    rd_check(2'd3, 32'd0, "R5 rdata untouched");
    // R7 command readback with ready in bit 7
    rd_check(2'd1, cmdw(PHY_AT, 2, 2, 0) | 32'h80, "R7 cmd readback");

    // R3 write, divider 1
    wr(2'd2, 32'h1234_A5C3);
    rd_check(2'd2, 32'h0000_A5C3, "R3 wdata readback");
    wr(2'd1, cmdw(PHY_AT, 4, 1, 1));
    @(negedge clk);
    chk("R7 busy after start", {31'd0, host_rdata[7]}, 32'd0);
    wait_idle();
    rd_check(2'd3, 32'd0, "R3 write leaves rdata");

    // R3 field positions: register 31, other PHY
    wr(2'd2, 32'h0000_0F0F);
    wr(2'd1, cmdw(5'd21, 31, 1, 1));
    wait_idle();

    // R4 read, divider 3
    wr(2'd0, 32'h43);
    wr(2'd1, cmdw(PHY_AT, 2, 2, 1));
    wait_idle();
    rd_check(2'd3, {16'd0, phy_val(2)}, "R4 read data");
    wr(2'd3, 32'h0000_1111);
    rd_check(2'd3, {16'd0, phy_val(2)}, "R4 rdata write ignored");

    // R6 absent PHY
    wr(2'd1, cmdw(9, 1, 2, 1));
    wait_idle();
    rd_check(2'd3, 32'h0000_FFFF, "R6 absent phy");

    // R10 start while busy, divider 2
    wr(2'd0, 32'h42);
    wr(2'd1, cmdw(PHY_AT, 3, 2, 1));
    repeat (60) @(negedge clk);
    wr(2'd1, cmdw(PHY_AT, 5, 1, 1));
    repeat (20) @(negedge clk);
    wr(2'd1, cmdw(PHY_AT, 6, 2, 1));
    wait_idle();
    rd_check(2'd3, {16'd0, phy_val(3)}, "R10 first read survives");

    summary();
    $finish;
  end
endmodule